// File: doc/BRIEF.md
# Interrupt Enable and Delegation Selector

This block decides, every cycle, whether the core should take an interrupt and which one. It forms the set of interrupts that are both pending and individually enabled, then gates each of them by one of two global enables. An interrupt that has not been handed down to the supervisor level is gated by the machine-level enable. An interrupt that has been handed down is gated by the supervisor-level enable. Each enable depends on the current privilege level and on a global interrupt-enable bit.

Of the interrupts that survive the gating, the lowest-numbered one wins. There is no programmable priority. The result is registered once so that it lines up with the core's trap-decision stage. The cause word carries the interrupt flag in its most significant bit and the winning index in its low bits.

Top module: `intr_pick`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, take_o is 0 and cause_o is all zeros.
- R2: A line counts as a candidate only if its bit is set in both pend_i and en_i. A line with only one of the two bits set is never reported.
- R3: A candidate whose deleg_i bit is 0 survives in these cases: privilege is U (0), S (1) or the reserved code 2, whatever mie_i is; or privilege is M (3) and mie_i is 1. In M with mie_i at 0 it is masked.
- R4: A candidate whose deleg_i bit is 1 survives in these cases: privilege is U, whatever sie_i is; or privilege is S and sie_i is 1. In M or in code 2 it is always masked.
- R5: When several candidates survive, the reported index is the lowest surviving bit position. Masked lower candidates do not block higher survivors.
- R6: When take_o is 1, cause_o bit XLEN-1 is 1. Bits [$clog2(NUM_IRQ)-1:0] hold the winning index, and all other bits are 0.
- R7: When no candidate survives, take_o is 0 and cause_o is all zeros.
- R8: take_o and cause_o reflect the inputs sampled at the previous rising clock edge. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_IRQ | Pending interrupt lines |
| en_i | input | NUM_IRQ | Per-line enables |
| deleg_i | input | NUM_IRQ | Per-line delegation to supervisor level |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| mie_i | input | 1 | Global machine interrupt enable |
| sie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | Take-interrupt strobe, registered |
| cause_o | output | XLEN | Interrupt flag in the top bit, winning index in the low bits |

## Verification
Two things can happen in the same cycle: the supervisor-level gating of delegated lines and the machine-level gating of non-delegated lines. The bench provokes this by making a low-numbered delegated line and a higher-numbered non-delegated line pending together. It then flips the privilege and the two global enables. It checks whether the reported cause moves to the higher line when the lower one is masked, and returns to the lower line when that one is enabled. It also applies a long run of random vectors on back-to-back cycles. These are judged one cycle later against a model written from the requirements.

// File: rtl/intr_pick_pkg.sv
package intr_pick_pkg;
  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/intr_pick_gate.sv
module intr_pick_gate
  import intr_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  priv_e              priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic [NUM_IRQ-1:0] surv_o
);
  logic               m_on, s_on;
  logic [NUM_IRQ-1:0] cand;

  always_comb begin
    m_on = (priv_i != PRV_M) || mie_i;
    s_on = (priv_i == PRV_U) || ((priv_i == PRV_S) && sie_i);
    cand = pend_i & en_i;
  end

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_mask
    assign surv_o[gi] = cand[gi] & (deleg_i[gi] ? s_on : m_on);
  end
endmodule

// File: rtl/intr_pick_lsb.sv
module intr_pick_lsb #(
  parameter int NUM_IRQ = 16,
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               any_o,
  output logic [IDXW-1:0]    idx_o
);
  logic [NUM_IRQ:0]   seen;
  logic [NUM_IRQ-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_chain
    assign seen[gi+1] = seen[gi] | vec_i[gi];
    assign first[gi]  = vec_i[gi] & ~seen[gi];
  end
  assign any_o = seen[NUM_IRQ];

  // first is one-hot, so OR-ing indices is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (first[i]) idx_o = idx_o | IDXW'(i);
    end
  end
endmodule

// File: rtl/intr_pick.sv
module intr_pick
  import intr_pick_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic               take_o,
  output logic [XLEN-1:0]    cause_o
);
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] surv;
  logic               any;
  logic [IDXW-1:0]    idx;
  logic [XLEN-1:0]    cause_d;

  intr_pick_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend_i (pend_i),
    .en_i   (en_i),
    .deleg_i(deleg_i),
    .priv_i (priv_e'(priv_i)),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .surv_o (surv)
  );

  intr_pick_lsb #(.NUM_IRQ(NUM_IRQ)) u_lsb (
    .vec_i(surv),
    .any_o(any),
    .idx_o(idx)
  );

  always_comb begin
    cause_d = '0;
    if (any) begin
      cause_d[XLEN-1]   = 1'b1;
      cause_d[IDXW-1:0] = idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      take_o  <= any;
      cause_o <= cause_d;
    end
  end
endmodule

// File: rtl/intr_pick_chk.sv
module intr_pick_chk #(
  parameter int XLEN    = 64,
  parameter int NUM_IRQ = 16,
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               mie_i,
  input logic               sie_i,
  input logic               take_o,
  input logic [XLEN-1:0]    cause_o
);
  logic [NUM_IRQ-1:0] cand_q, deleg_q;
  logic [1:0]         priv_q;
  logic               mie_q;
  logic [IDXW-1:0]    win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= '0;
      deleg_q <= '0;
      priv_q  <= '0;
      mie_q   <= 1'b0;
    end else begin
      cand_q  <= pend_i & en_i;
      deleg_q <= deleg_i;
      priv_q  <= priv_i;
      mie_q   <= mie_i;
    end
  end

  assign win = cause_o[IDXW-1:0];

  // R2
  cand_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> cand_q[win]);

  // R3
  m_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && priv_q == 2'd3 && !mie_q) |-> deleg_q[win]);

  // R4
  deleg_in_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && priv_q[1]) |-> !deleg_q[win]);

  // R6
  cause_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:IDXW] == '0));

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> cause_o == '0);
endmodule

bind intr_pick intr_pick_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pend_i (pend_i),
  .en_i   (en_i),
  .deleg_i(deleg_i),
  .priv_i (priv_i),
  .mie_i  (mie_i),
  .sie_i  (sie_i),
  .take_o (take_o),
  .cause_o(cause_o)
);

// File: tb/intr_pick_tb.sv
module intr_pick_tb;
  localparam int XLEN = 64;
  localparam int N    = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    pend_i = '0, en_i = '0, deleg_i = '0;
  logic [1:0]      priv_i = 2'd3;
  logic            mie_i = 1'b0, sie_i = 1'b0;
  logic            take_o;
  logic [XLEN-1:0] cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic            take;
    logic [XLEN-1:0] cause;
    string           tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;

  intr_pick #(.XLEN(XLEN), .NUM_IRQ(N)) u_dut (.*);

  function automatic exp_t model(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
                                 logic [1:0] pv, logic m, logic s, string tag);
    exp_t r;
    logic m_ok, s_ok, ok;
    m_ok = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd2) || m;
    s_ok = (pv == 2'd0) || ((pv == 2'd1) && s);
    r.take = 1'b0; r.cause = '0; r.tag = tag;
    for (int i = N - 1; i >= 0; i--) begin
      ok = p[i] && e[i] && (d[i] ? s_ok : m_ok);
      if (ok) begin
        r.take  = 1'b1;
        r.cause = (64'd1 << (XLEN - 1)) | 64'(i);
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
                       input logic [1:0] pv, input logic m, input logic s, input string tag);
    @(negedge clk_i);
    pend_i = p; en_i = e; deleg_i = d; priv_i = pv; mie_i = m; sie_i = s;
    sb.push_back(model(p, e, d, pv, m, s, tag));
  endtask

  task automatic check(input string tag, input logic [XLEN:0] act, input logic [XLEN:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual take/cause %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per rising edge after it was driven
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(x.tag, {take_o, cause_o}, {x.take, x.cause});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a live candidate on the inputs
    pend_i = 16'h0001; en_i = 16'h0001; priv_i = 2'd0;
    #10;
    check("R1 in reset", {take_o, cause_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 after release", {take_o, cause_o}, '0);

    // R2
    drive(16'h0010, 16'h0000, '0, 2'd0, 1'b1, 1'b1, "R2 pend only");
    drive(16'h0000, 16'h0010, '0, 2'd0, 1'b1, 1'b1, "R2 en only");
    // R3
    drive(16'h0008, 16'h0008, '0, 2'd3, 1'b0, 1'b1, "R3 M mie0");
    drive(16'h0008, 16'h0008, '0, 2'd3, 1'b1, 1'b0, "R3 M mie1");
    drive(16'h0008, 16'h0008, '0, 2'd0, 1'b0, 1'b0, "R3 U");
    drive(16'h0008, 16'h0008, '0, 2'd1, 1'b0, 1'b0, "R3 S");
    drive(16'h0008, 16'h0008, '0, 2'd2, 1'b0, 1'b0, "R3 code2");
    // R4
    drive(16'h0020, 16'h0020, 16'h0020, 2'd3, 1'b1, 1'b1, "R4 M");
    drive(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b1, 1'b0, "R4 S sie0");
    drive(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b1, "R4 S sie1");
    drive(16'h0020, 16'h0020, 16'h0020, 2'd0, 1'b0, 1'b0, "R4 U");
    drive(16'h0020, 16'h0020, 16'h0020, 2'd2, 1'b1, 1'b1, "R4 code2");
    // R5: delegated low line vs non-delegated high line in one cycle
    drive(16'h0082, 16'h0082, 16'h0002, 2'd1, 1'b0, 1'b0, "R5 deleg masked");
    drive(16'h0082, 16'h0082, 16'h0002, 2'd1, 1'b0, 1'b1, "R5 deleg wins");
    drive(16'h0082, 16'h0082, 16'h0002, 2'd3, 1'b1, 1'b1, "R5 M skips deleg");
    drive(16'h8210, 16'hffff, '0, 2'd3, 1'b1, 1'b0, "R5 lowest of three");
    // R6 boundaries
    drive(16'h8000, 16'h8000, '0, 2'd0, 1'b0, 1'b0, "R6 top line");
    drive(16'h0001, 16'h0001, '0, 2'd0, 1'b0, 1'b0, "R6 line zero");
    // R7
    drive(16'hffff, 16'hffff, '0, 2'd3, 1'b0, 1'b0, "R7 all masked");
    // R8: back-to-back random vectors
    for (int k = 0; k < 200; k++) begin
      drive(N'($urandom), N'($urandom), N'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), "R8 random");
    end
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule